// File: doc/BRIEF.md
# Packed Lane Permute and Mask Unit

This block is a one-stage registered datapath for 128-bit vector registers viewed as four 32-bit lanes or as two 64-bit halves. Each cycle it may accept one operation: two 128-bit operands (a destination operand `dst_a` and a source operand `src_b`), a 4-bit opcode, a 3-bit compare predicate and a valid strobe. One clock later it presents the 128-bit result together with `out_valid`.

It covers the following operations:

- moves between the 64-bit halves;
- high and low lane interleave;
- a scalar insert into lane 0;
- bitwise AND, OR, XOR and AND-NOT;
- lane-wise IEEE-754 single-precision compares that yield all-ones or all-zeros lane masks;
- gathering the four lane sign bits into a 4-bit mask.

The unit holds no architectural register state. The surrounding pipeline supplies the operands and writes the result back.

The design has no multi-state controller. The output stage has only two conditions: a valid result is presented the cycle after `in_valid`, and otherwise nothing is presented while the last result is held.

Top module: `lane_permute_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `result` to zero and `out_valid` to 0 at the next rising clock edge.
- R2: `out_valid` equals the `in_valid` of the previous cycle. The result is registered one clock after `in_valid`. When `in_valid` is low, `result` keeps its value.
- R3: Opcode 0 (high-to-low move): result[63:0] = src_b[127:64] and result[127:64] = dst_a[127:64].
- R4: Opcode 1 (low-to-high move): result[127:64] = src_b[63:0] and result[63:0] = dst_a[63:0].
- R5: Opcode 2 (high interleave). Writing lanes from lane 3 down to lane 0, with lane i at bits [32i+31:32i], the result is {src lane 3, dst lane 3, src lane 2, dst lane 2}.
- R6: Opcode 3 (low interleave): the result lanes, from lane 3 down to lane 0, are {src lane 1, dst lane 1, src lane 0, dst lane 0}.
- R7: Opcode 4 (scalar insert): result lane 0 = src lane 0, and lanes 1 to 3 are copied from `dst_a`.
- R8: Opcodes 5, 6, 7 and 8 give, over all 128 bits, dst&src, dst|src, dst^src and (~dst)&src respectively.
- R9: Opcode 9 (compare) tests each lane with the condition "dst lane pred src lane" on single-precision values. The predicate codes are 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered. A lane becomes 32'hFFFFFFFF when the condition holds and 0 when it does not. +0 and -0 compare equal.
- R10: A lane in which either operand is a NaN (exponent all ones, mantissa non-zero) is unordered. For such a lane, predicates 0, 1, 2 and 7 give 0, and predicates 3, 4, 5 and 6 give all ones.
- R11: Opcode 10 (sign gather): result[i] = bit 31 of dst lane i for i = 0 to 3, and result[127:4] = 0.
- R12: Opcodes 11 to 15 are reserved. They produce an all-zero result with `out_valid` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation code (see requirements) |
| pred | input | 3 | Compare predicate, used by opcode 9 |
| dst_a | input | 128 | Destination operand, four 32-bit lanes |
| src_b | input | 128 | Source operand, four 32-bit lanes |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128 | Registered result or sign mask |

## Verification
Each operation is first driven with lane patterns whose lane values are all different. A result that swaps lanes or halves, or mixes the two operands, therefore shows up at once.

Compares are driven with a fixed operand pair under all eight predicates. The pair holds a NaN lane, a +0 against -0 lane, a positive lane where dst is less than src, and a negative lane where dst is greater than src. This separates sign handling, zero equality and unordered handling.

A long run of back-to-back operations then follows, with gaps where the strobe is low. Its operands are random and include injected special values. The run checks the hold behaviour and the one-cycle latency against a behavioural model on every clock. The run also covers reserved opcodes and a reset in mid-stream.

// File: rtl/lpu_pkg.sv
package lpu_pkg;
    parameter int LANE_W = 32;
    parameter int EXP_W  = 8;
    parameter int MAN_W  = 23;
    parameter int LANES  = 4;
    localparam int VEC_W  = LANE_W * LANES;
    localparam int HALF_W = VEC_W / 2;
    localparam int HALF_LANES = LANES / 2;

    typedef enum logic [3:0] {
        OP_MOV_HL   = 4'd0,
        OP_MOV_LH   = 4'd1,
        OP_ILV_HI   = 4'd2,
        OP_ILV_LO   = 4'd3,
        OP_SCALAR   = 4'd4,
        OP_AND      = 4'd5,
        OP_OR       = 4'd6,
        OP_XOR      = 4'd7,
        OP_ANDN     = 4'd8,
        OP_CMP      = 4'd9,
        OP_SIGNMASK = 4'd10
    } lpu_op_e;

    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } lpu_pred_e;
endpackage

// File: rtl/lpu_shuffle.sv
module lpu_shuffle
    import lpu_pkg::*;
(
    input  logic [3:0]       op,
    input  logic [VEC_W-1:0] dst,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] shuf_res
);
    logic [VEC_W-1:0] ilv_hi;
    logic [VEC_W-1:0] ilv_lo;

    // Interleave: even result lanes come from dst, odd ones from src
    for (genvar i = 0; i < HALF_LANES; i++) begin : g_ilv
        assign ilv_hi[(2*i)*LANE_W   +: LANE_W] = dst[(HALF_LANES+i)*LANE_W +: LANE_W];
        assign ilv_hi[(2*i+1)*LANE_W +: LANE_W] = src[(HALF_LANES+i)*LANE_W +: LANE_W];
        assign ilv_lo[(2*i)*LANE_W   +: LANE_W] = dst[i*LANE_W +: LANE_W];
        assign ilv_lo[(2*i+1)*LANE_W +: LANE_W] = src[i*LANE_W +: LANE_W];
    end

    always_comb begin
        unique case (op)
            OP_MOV_HL: shuf_res = {dst[VEC_W-1:HALF_W], src[VEC_W-1:HALF_W]};
            OP_MOV_LH: shuf_res = {src[HALF_W-1:0], dst[HALF_W-1:0]};
            OP_ILV_HI: shuf_res = ilv_hi;
            OP_ILV_LO: shuf_res = ilv_lo;
            OP_SCALAR: shuf_res = {dst[VEC_W-1:LANE_W], src[LANE_W-1:0]};
            default:   shuf_res = '0;
        endcase
    end
endmodule

// File: rtl/lpu_logic.sv
module lpu_logic
    import lpu_pkg::*;
(
    input  logic [3:0]       op,
    input  logic [VEC_W-1:0] dst,
    input  logic [VEC_W-1:0] src,
    output logic [VEC_W-1:0] logic_res
);
    always_comb begin
        unique case (op)
            OP_AND:  logic_res = dst & src;
            OP_OR:   logic_res = dst | src;
            OP_XOR:  logic_res = dst ^ src;
            OP_ANDN: logic_res = ~dst & src;
            default: logic_res = '0;
        endcase
    end
endmodule

// File: rtl/lpu_lane_cmp.sv
module lpu_lane_cmp
    import lpu_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic [2:0]     pred,
    input  logic [EW+MW:0] a,
    input  logic [EW+MW:0] b,
    output logic           hit
);
    localparam int SB = EW + MW;

    logic a_nan, b_nan, unord, both_zero, eq, lt;

    assign a_nan     = (&a[SB-1:MW]) && (|a[MW-1:0]);
    assign b_nan     = (&b[SB-1:MW]) && (|b[MW-1:0]);
    assign unord     = a_nan || b_nan;
    assign both_zero = ~|a[SB-1:0] && ~|b[SB-1:0];
    assign eq        = !unord && ((a == b) || both_zero);

    always_comb begin
        if (unord || both_zero)   lt = 1'b0;
        else if (a[SB] != b[SB])  lt = a[SB];
        else if (!a[SB])          lt = a[SB-1:0] < b[SB-1:0];
        else                      lt = a[SB-1:0] > b[SB-1:0];
    end

    always_comb begin
        unique case (pred)
            PR_EQ:    hit = eq;
            PR_LT:    hit = lt;
            PR_LE:    hit = lt || eq;
            PR_UNORD: hit = unord;
            PR_NEQ:   hit = !eq;
            PR_NLT:   hit = !lt;
            PR_NLE:   hit = !(lt || eq);
            PR_ORD:   hit = !unord;
            default:  hit = 1'b0;
        endcase
    end

    // R10
    always_comb begin
        nan_excl_chk: assert (!(unord && (eq || lt)));
    end
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [2:0]       pred,
    input  logic [127:0]     dst_a,
    input  logic [127:0]     src_b,
    output logic             out_valid,
    output logic [127:0]     result
);
    logic [VEC_W-1:0] shuf_res, logic_res, cmp_res, next_res;
    logic [LANES-1:0] sign_bits;
    logic [VEC_W-1:0] res_q;
    logic             vld_q;

    lpu_shuffle u_shuf (.op(op), .dst(dst_a), .src(src_b), .shuf_res(shuf_res));
    lpu_logic   u_logic (.op(op), .dst(dst_a), .src(src_b), .logic_res(logic_res));

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        lpu_lane_cmp u_cmp (
            .pred(pred),
            .a(dst_a[i*LANE_W +: LANE_W]),
            .b(src_b[i*LANE_W +: LANE_W]),
            .hit(hit)
        );
        assign cmp_res[i*LANE_W +: LANE_W] = {LANE_W{hit}};
        assign sign_bits[i] = dst_a[i*LANE_W + LANE_W - 1];
    end

    always_comb begin
        unique case (op)
            OP_MOV_HL, OP_MOV_LH, OP_ILV_HI, OP_ILV_LO, OP_SCALAR:
                next_res = shuf_res;
            OP_AND, OP_OR, OP_XOR, OP_ANDN:
                next_res = logic_res;
            OP_CMP:
                next_res = cmp_res;
            OP_SIGNMASK:
                next_res = {{(VEC_W-LANES){1'b0}}, sign_bits};
            default:
                next_res = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) res_q <= next_res;
        end
    end

    assign result    = res_q;
    assign out_valid = vld_q;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
    // R3
    hl_move_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MOV_HL) |=>
        (result[127:64] == $past(dst_a[127:64]) && result[63:0] == $past(src_b[127:64])));
    // R7
    scalar_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SCALAR) |=>
        (result[127:32] == $past(dst_a[127:32]) && result[31:0] == $past(src_b[31:0])));
    // R9
    cmp_full_lane_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_CMP) |=>
        ((result[31:0] == '0 || result[31:0] == '1) && (result[63:32] == '0 || result[63:32] == '1) &&
         (result[95:64] == '0 || result[95:64] == '1) && (result[127:96] == '0 || result[127:96] == '1)));
    // R11
    sign_gather_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_SIGNMASK) |=>
        (result[127:4] == '0 && result[3:0] ==
         {$past(dst_a[127]), $past(dst_a[95]), $past(dst_a[63]), $past(dst_a[31])}));
    // R12
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 4'd10) |=> (result == '0));
endmodule

// File: tb/lane_permute_unit_tb_top.sv
`timescale 1ns/1ps
module lane_permute_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [2:0]   pred = '0;
    logic [127:0] dst_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [127:0] last_res = '0;

    always #5 clk = ~clk;

    lane_permute_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .pred(pred),
        .dst_a(dst_a), .src_b(src_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [31:0] ln(logic [127:0] v, int i);
        return v[i*32 +: 32];
    endfunction

    function automatic bit is_nan(logic [31:0] v);
        return (v[30:23] == 8'hFF) && (v[22:0] != 0);
    endfunction

    function automatic longint fkey(logic [31:0] v);
        longint m = longint'(v[30:0]);
        return v[31] ? -m : m;
    endfunction

    function automatic bit cmp_model(logic [2:0] p, logic [31:0] a, logic [31:0] b);
        bit u = is_nan(a) || is_nan(b);
        bit e = !u && (fkey(a) == fkey(b));
        bit l = !u && (fkey(a) < fkey(b));
        case (p)
            3'd0: return e;
            3'd1: return l;
            3'd2: return l || e;
            3'd3: return u;
            3'd4: return !e;
            3'd5: return !l;
            3'd6: return !(l || e);
            default: return !u;
        endcase
    endfunction

    function automatic logic [127:0] model(logic [3:0] o, logic [2:0] p, logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        case (o)
            4'd0: r = {a[127:64], b[127:64]};
            4'd1: r = {b[63:0], a[63:0]};
            4'd2: r = {ln(b,3), ln(a,3), ln(b,2), ln(a,2)};
            4'd3: r = {ln(b,1), ln(a,1), ln(b,0), ln(a,0)};
            4'd4: r = {a[127:32], b[31:0]};
            4'd5: r = a & b;
            4'd6: r = a | b;
            4'd7: r = a ^ b;
            4'd8: r = ~a & b;
            4'd9: for (int i = 0; i < 4; i++) r[i*32 +: 32] = cmp_model(p, ln(a,i), ln(b,i)) ? 32'hFFFFFFFF : 32'h0;
            4'd10: for (int i = 0; i < 4; i++) r[i] = a[i*32+31];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [3:0] o);
        case (o)
            4'd0: return "R3";
            4'd1: return "R4";
            4'd2: return "R5";
            4'd3: return "R6";
            4'd4: return "R7";
            4'd5, 4'd6, 4'd7, 4'd8: return "R8";
            4'd9: return "R9";
            4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic check_res(string tag, logic [127:0] exp_r, logic exp_v);
        checks++;
        if (result !== exp_r || out_valid !== exp_v) begin
            errors++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     tag, result, out_valid, exp_r, exp_v);
        end
        last_res = result;
    endtask

    // Called at a negedge; drives one operation and checks it at the next negedge
    task automatic do_op(logic [3:0] o, logic [2:0] p, logic [127:0] a, logic [127:0] b, string tag);
        logic [127:0] exp_r = model(o, p, a, b);
        in_valid = 1'b1; op = o; pred = p; dst_a = a; src_b = b;
        @(negedge clk);
        check_res(tag, exp_r, 1'b1);
    endtask

    task automatic idle_cycle(string tag);
        logic [127:0] held = last_res;
        in_valid = 1'b0; op = 4'd5; dst_a = ~dst_a; src_b = ~src_b;
        @(negedge clk);
        check_res(tag, held, 1'b0);
    endtask

    function automatic logic [31:0] pick_lane();
        logic [31:0] pool [8] = '{32'h00000000, 32'h80000000, 32'h3F800000, 32'hBF800000,
                                   32'h7FC00000, 32'h7F800000, 32'h40000000, 32'hC0000000};
        if ($urandom_range(0, 2) == 0) return pool[$urandom_range(0, 7)];
        return $urandom();
    endfunction

    localparam logic [127:0] A1 = 128'h44444444_33333333_22222222_11111111;
    localparam logic [127:0] B1 = 128'hDDDDDDDD_CCCCCCCC_BBBBBBBB_AAAAAAAA;
    // lanes 3..0: -1.0, +0, 1.0, NaN   vs   -2.0, -0, 2.0, 1.0
    localparam logic [127:0] CA = {32'hBF800000, 32'h00000000, 32'h3F800000, 32'h7FC00000};
    localparam logic [127:0] CB = {32'hC0000000, 32'h80000000, 32'h40000000, 32'h3F800000};

    initial begin
        dst_a = A1; src_b = B1; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        check_res("R1", '0, 1'b0);  // reset held with in_valid high
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        check_res("R2", '0, 1'b0);

        do_op(4'd0, 3'd0, A1, B1, "R3");
        do_op(4'd1, 3'd0, A1, B1, "R4");
        do_op(4'd2, 3'd0, A1, B1, "R5");
        do_op(4'd3, 3'd0, A1, B1, "R6");
        do_op(4'd4, 3'd0, A1, B1, "R7");
        do_op(4'd5, 3'd0, A1, B1, "R8");
        do_op(4'd6, 3'd0, A1, B1, "R8");
        do_op(4'd7, 3'd0, A1, B1, "R8");
        do_op(4'd8, 3'd0, 128'hFFFF0000_FFFF0000_0F0F0F0F_00000000, B1, "R8");
        idle_cycle("R2");
        idle_cycle("R2");
        for (int p = 0; p < 8; p++) do_op(4'd9, 3'(p), CA, CB, (p == 3 || p == 7) ? "R10" : "R9");
        do_op(4'd10, 3'd0, CA, CB, "R11");
        do_op(4'd10, 3'd0, 128'h7FFFFFFF_80000000_FFFFFFFF_00000000, B1, "R11");
        do_op(4'd11, 3'd0, A1, B1, "R12");
        do_op(4'd15, 3'd0, A1, B1, "R12");

        for (int n = 0; n < 400; n++) begin
            logic [3:0] o = 4'($urandom_range(0, 15));
            logic [127:0] a = {pick_lane(), pick_lane(), pick_lane(), pick_lane()};
            logic [127:0] b = {pick_lane(), pick_lane(), pick_lane(), pick_lane()};
            if ($urandom_range(0, 4) == 0) idle_cycle("R2");
            else do_op(o, 3'($urandom_range(0, 7)), a, b, tag_of(o));
        end

        do_op(4'd7, 3'd0, A1, B1, "R8");
        rst = 1'b1;
        @(negedge clk);
        check_res("R1", '0, 1'b0);
        rst = 1'b0;
        do_op(4'd2, 3'd0, CA, CB, "R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule